// File: doc/BRIEF.md
# Thermal Sideband Alert Monitor

This block watches a set of per-core temperature readings and drives three active-low sideband outputs: a hot indication, an early-warning alert and a catastrophic trip. The hot output fires when any core reaches a programmable hot threshold. The alert output fires at a lower threshold, which is the hot threshold minus an unsigned programmable offset. The trip output fires when any core reaches a fixed trip temperature. Once it has fired, it stays latched until power-good drops.

A platform forced-hot input is watched separately. It never drives the hot output. A status bit reports whether the most recent forced-hot pulse was shorter than a minimum cycle count set by a parameter. All three sideband outputs are held inactive (high) unless power-good is high and platform reset is low. Software writes the two thresholds through a small write port. Offset writes take effect only after platform reset has been released.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `therm_alert_mon`

## Requirements
- R1: While `rst_n` is low, `hot_n`, `alert_n` and `trip_n` are 1 and `force_short` is 0. After `rst_n` is released, the hot threshold is `HOT_RESET` (90) and the offset is 0.
- R2: One cycle after an edge where the platform is valid and the largest core temperature is greater than or equal to the hot threshold, `hot_n` is 0. Otherwise it is 1.
- R3: `alert_n` behaves like `hot_n`, but against the hot threshold minus the offset. When the offset exceeds the hot threshold, the alert threshold is 0.
- R4: While `plat_rst` is 1, the offset is forced to 0 and offset writes are ignored.
- R5: `force_hot` has no effect on `hot_n`.
- R6: A core at or above `TRIP_TEMP` (125) while `pwr_good` is 1 latches a trip. The latch is set regardless of `plat_rst` and `force_hot`, and it stays set after the temperature falls.
- R7: The trip latch clears only when `pwr_good` is sampled low.
- R8: One cycle after an edge where `pwr_good` is 0 or `plat_rst` is 1, all three sideband outputs are 1.
- R9: On the first edge where `force_hot` is sampled low after a run of N sampled-high edges, `force_short` becomes 1 if N < `MIN_FORCE` (8), and becomes 0 otherwise. Between releases it holds its value.
- R10: Writes use `cfg_sel` 0 for the hot threshold and `cfg_sel` 1 for the offset. A write takes effect at the edge where `cfg_we` is 1, and the thresholds it sets apply from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good | input | 1 | Platform power is good |
| plat_rst | input | 1 | Platform reset, active high |
| core_temp | input | NUM_CORES*TEMP_W | Packed core temperatures, core 0 in the low bits |
| force_hot | input | 1 | Platform forced-hot request, active high |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | 0 selects the hot threshold, 1 selects the offset |
| cfg_wdata | input | TEMP_W | Write data |
| hot_n | output | 1 | Hot indication, active low |
| alert_n | output | 1 | Early-warning alert, active low |
| trip_n | output | 1 | Catastrophic trip, active low |
| force_short | output | 1 | Last forced-hot pulse was too short |

## Verification
A corrupted threshold register shows up as `hot_n` or `alert_n` switching at the wrong temperature. This appears one cycle after the first reading that falls between the correct threshold and the wrong one. A trip latch that clears or sets wrongly shows on `trip_n` within one cycle of the next valid edge. A stuck pulse counter shows only on the next release of `force_hot`, through `force_short`. The random phase therefore sweeps temperatures across all three thresholds and releases `force_hot` often.

// File: rtl/therm_pkg.sv
package therm_pkg;
  typedef enum logic {
    SEL_HOT    = 1'b0,
    SEL_OFFSET = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/therm_max.sv
module therm_max #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N*W-1:0] temps,
  output logic [W-1:0]   max_temp
);
  logic [W-1:0] run [N];

  assign run[0] = temps[W-1:0];

  generate
    for (genvar i = 1; i < N; i++) begin : g_cmp
      assign run[i] = (temps[i*W +: W] > run[i-1]) ? temps[i*W +: W] : run[i-1];
    end
  endgenerate

  assign max_temp = run[N-1];
endmodule

// File: rtl/therm_cfg.sv
module therm_cfg
  import therm_pkg::*;
#(
  parameter int         W         = 8,
  parameter logic [W-1:0] HOT_RESET = 8'd90
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         plat_rst,
  input  logic         cfg_we,
  input  logic         cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] hot_thr,
  output logic [W-1:0] alert_thr
);
  logic [W-1:0] hot_q, hot_d, off_q, off_d;

  always_comb begin
    hot_d = hot_q;
    off_d = off_q;
    if (cfg_we && cfg_sel == SEL_HOT) hot_d = cfg_wdata;
    if (plat_rst) off_d = '0;
    else if (cfg_we && cfg_sel == SEL_OFFSET) off_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= HOT_RESET;
      off_q <= '0;
    end else begin
      hot_q <= hot_d;
      off_q <= off_d;
    end
  end

  assign hot_thr   = hot_q;
  assign alert_thr = (hot_q >= off_q) ? (hot_q - off_q) : '0;

  // R4
  offset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plat_rst |=> (off_q == '0));

  // R3
  always_comb begin
    if (rst_n) alert_below_hot_chk: assert (alert_thr <= hot_thr);
  end
endmodule

// File: rtl/therm_force_mon.sv
module therm_force_mon #(
  parameter int MIN_FORCE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_hot,
  output logic force_short
);
  localparam int CW = $clog2(MIN_FORCE + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_FORCE);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          f_q, short_q, short_d;

  always_comb begin
    cnt_d   = force_hot ? ((cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1) : '0;
    short_d = short_q;
    if (!force_hot && f_q) short_d = (cnt_q < CMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      f_q     <= 1'b0;
      short_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      f_q     <= force_hot;
      short_q <= short_d;
    end
  end

  assign force_short = short_q;

  // R9
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hot || !f_q) |=> $stable(force_short));
endmodule

// File: rtl/therm_alert_mon.sv
module therm_alert_mon
  import therm_pkg::*;
#(
  parameter int           NUM_CORES = 4,
  parameter int           TEMP_W    = 8,
  parameter logic [TEMP_W-1:0] HOT_RESET = 8'd90,
  parameter logic [TEMP_W-1:0] TRIP_TEMP = 8'd125,
  parameter int           MIN_FORCE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pwr_good,
  input  logic                          plat_rst,
  input  logic [NUM_CORES*TEMP_W-1:0]   core_temp,
  input  logic                          force_hot,
  input  logic                          cfg_we,
  input  logic                          cfg_sel,
  input  logic [TEMP_W-1:0]             cfg_wdata,
  output logic                          hot_n,
  output logic                          alert_n,
  output logic                          trip_n,
  output logic                          force_short
);
  logic [TEMP_W-1:0] max_temp, hot_thr, alert_thr;
  logic valid, trip_q, trip_d, hot_d, alert_d, tripo_d;
  logic hot_q, alert_q, tripo_q;

  therm_max #(.N(NUM_CORES), .W(TEMP_W)) u_max (
    .temps(core_temp), .max_temp(max_temp));

  therm_cfg #(.W(TEMP_W), .HOT_RESET(HOT_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .plat_rst(plat_rst), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hot_thr(hot_thr), .alert_thr(alert_thr));

  therm_force_mon #(.MIN_FORCE(MIN_FORCE)) u_force (
    .clk(clk), .rst_n(rst_n), .force_hot(force_hot), .force_short(force_short));

  assign valid = pwr_good && !plat_rst;

  always_comb begin
    trip_d  = pwr_good ? (trip_q || (max_temp >= TRIP_TEMP)) : 1'b0;
    hot_d   = valid && (max_temp >= hot_thr);
    alert_d = valid && (max_temp >= alert_thr);
    tripo_d = valid && trip_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q  <= 1'b0;
      hot_q   <= 1'b0;
      alert_q <= 1'b0;
      tripo_q <= 1'b0;
    end else begin
      trip_q  <= trip_d;
      hot_q   <= hot_d;
      alert_q <= alert_d;
      tripo_q <= tripo_d;
    end
  end

  assign hot_n   = !hot_q;
  assign alert_n = !alert_q;
  assign trip_n  = !tripo_q;

  // R8
  gate_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good || plat_rst) |=> (hot_n && alert_n && trip_n));

  // R6
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_n && pwr_good && !plat_rst) |=> !trip_n);

  // R3
  hot_implies_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hot_n |-> !alert_n);

  // R7
  trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> trip_n);
endmodule

// File: tb/therm_alert_mon_test.sv
module therm_alert_mon_test;
  localparam int NC = 4;
  localparam int W = 8;
  localparam int HOT_RESET = 90;
  localparam int TRIP_TEMP = 125;
  localparam int MIN_FORCE = 8;

  logic clk = 0, rst_n = 0, pwr_good = 0, plat_rst = 1, force_hot = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [W-1:0] cfg_wdata = 0;
  logic [W-1:0] t [NC];
  logic [NC*W-1:0] core_temp;
  logic hot_n, alert_n, trip_n, force_short;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_hot, m_off, m_cnt;
  bit m_trip, m_prevf, m_short;
  bit e_hot, e_alert, e_trip;

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < NC; i++) core_temp[i*W +: W] = t[i];

  therm_alert_mon uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .plat_rst(plat_rst),
    .core_temp(core_temp), .force_hot(force_hot), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .hot_n(hot_n),
    .alert_n(alert_n), .trip_n(trip_n), .force_short(force_short));

  task automatic chk(string tag, string what, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  function automatic int max_t();
    int m = 0;
    for (int i = 0; i < NC; i++) if (int'(t[i]) > m) m = int'(t[i]);
    return m;
  endfunction

  task automatic model();
    int mx = max_t();
    bit v = pwr_good && !plat_rst;
    int athr = (m_hot >= m_off) ? m_hot - m_off : 0;
    bit tn;
    e_hot   = !(v && mx >= m_hot);
    e_alert = !(v && mx >= athr);
    tn = pwr_good ? (m_trip || mx >= TRIP_TEMP) : 1'b0;
    e_trip = !(v && tn);
    m_trip = tn;
    if (!force_hot && m_prevf) m_short = (m_cnt < MIN_FORCE);
    m_cnt = force_hot ? ((m_cnt == MIN_FORCE) ? m_cnt : m_cnt + 1) : 0;
    m_prevf = force_hot;
    if (cfg_we && cfg_sel == 1'b0) m_hot = int'(cfg_wdata);
    if (plat_rst) m_off = 0;
    else if (cfg_we && cfg_sel == 1'b1) m_off = int'(cfg_wdata);
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    @(negedge clk);
    chk("R2", "hot_n", hot_n, e_hot);
    chk("R3", "alert_n", alert_n, e_alert);
    chk("R6", "trip_n", trip_n, e_trip);
    chk("R9", "force_short", force_short, m_short);
    cfg_we = 0;
  endtask

  task automatic set_all(int v);
    for (int i = 0; i < NC; i++) t[i] = W'(v);
  endtask

  task automatic wr(bit sel, int d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = W'(d);
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    set_all(40);
    m_hot = HOT_RESET; m_off = 0; m_cnt = 0;
    m_trip = 0; m_prevf = 0; m_short = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "hot_n", hot_n, 1'b1);
    chk("R1", "alert_n", alert_n, 1'b1);
    chk("R1", "trip_n", trip_n, 1'b1);
    chk("R1", "force_short", force_short, 1'b0);
    rst_n = 1;
    // R4: offset write during platform reset ignored
    wr(1'b1, 20);
    plat_rst = 0; pwr_good = 1;
    set_all(75); cyc();
    chk("R4", "alert_n after ignored write", alert_n, 1'b1);
    // R1: default hot threshold 90
    set_all(89); cyc();
    chk("R1", "hot_n at 89", hot_n, 1'b1);
    t[2] = 90; cyc();
    chk("R2", "hot_n at 90", hot_n, 1'b0);
    // R10, R3: offset write after reset release
    set_all(70); wr(1'b1, 20); cyc();
    chk("R10", "alert_n at 70 offset 20", alert_n, 1'b0);
    chk("R3", "hot_n at 70", hot_n, 1'b1);
    set_all(69); cyc();
    chk("R3", "alert_n at 69", alert_n, 1'b1);
    // R3: saturation
    wr(1'b1, 200); set_all(0); cyc();
    chk("R3", "alert_n saturated", alert_n, 1'b0);
    wr(1'b1, 0);
    // R5: forced hot does not raise hot
    force_hot = 1; set_all(40); cyc(); cyc();
    chk("R5", "hot_n under force", hot_n, 1'b1);
    force_hot = 0; cyc();
    chk("R9", "short after 2-cycle pulse", force_short, 1'b1);
    force_hot = 1; repeat (10) cyc();
    force_hot = 0; cyc();
    chk("R9", "long pulse", force_short, 1'b0);
    // R6, R7, R8: trip latch
    t[3] = 127; cyc();
    chk("R6", "trip_n raised", trip_n, 1'b0);
    set_all(40); cyc(); cyc();
    chk("R6", "trip_n sticky", trip_n, 1'b0);
    plat_rst = 1; cyc();
    chk("R8", "trip_n gated by reset", trip_n, 1'b1);
    plat_rst = 0; cyc();
    chk("R6", "trip_n held through reset", trip_n, 1'b0);
    pwr_good = 0; cyc();
    chk("R8", "outputs gated by power", trip_n & hot_n & alert_n, 1'b1);
    pwr_good = 1; cyc();
    chk("R7", "trip cleared", trip_n, 1'b1);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NC; i++) t[i] = W'(50 + ($urandom % 82));
      pwr_good = ($urandom % 40) != 0;
      plat_rst = ($urandom % 30) == 0;
      if (($urandom % 4) == 0) force_hot = ~force_hot;
      if (($urandom % 20) == 0) begin
        cfg_we = 1; cfg_sel = $urandom % 2;
        cfg_wdata = cfg_sel ? W'($urandom % 40) : W'(80 + ($urandom % 40));
      end
      cyc();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule